// File: doc/BRIEF.md
# Event-to-Counter Routing Table

This block records which programmable performance counter, if any, each supported hardware event feeds, and turns event pulses into per-counter increment strobes. Software programs the table by presenting a counter index and a selector word on a one-cycle write strobe. The block checks the write, then binds the event to the counter, leaves an existing binding alone, or removes every binding that points at that counter. A rejected write raises an error pulse.

Five events are supported, each on its own bit of the event pulse input: bit 0 is core cycles, bit 1 is retired instructions, bit 2 is data-TLB read miss, bit 3 is data-TLB write miss and bit 4 is instruction-TLB miss. An event index is 20 bits: a 4-bit type in bits [19:16] over a 16-bit code. For the cache type (type 1), the code holds a cache identifier in bits [15:3], an operation in bits [2:1] and a result in bit [0]. The strobe output has one bit per counter number. Bit c pulses in the same cycle as any input event that is bound to counter c.

Top module: `evt_ctr_router`

## Requirements
- R1: After reset no event is bound. `wr_err` and `unmapped_seen` are low, and no input pulse produces a strobe.
- R2: A write of a supported event index to a valid counter c binds the event. From then on, a pulse on that event's input bit drives `inc_strobe[c]` in the same cycle. The supported indices are 0x00001 (cycles, bit 0), 0x00002 (instructions, bit 1), 0x10019 (data-TLB read miss, bit 2), 0x1001B (data-TLB write miss, bit 3) and 0x10021 (instruction-TLB miss, bit 4).
- R3: A write whose selector is nonzero but whose low 20 bits match no supported index is rejected. It changes no binding.
- R4: Only counter indices from 3 to 2+NUM_CTRS are valid (3 to 10 by default). A write to any other index is rejected and changes no binding.
- R5: A write for an event that is already bound is accepted without error. The existing binding stays unchanged.
- R6: A write of an all-zero selector word to a valid counter removes every binding to that counter. Other bindings are kept, and no error is raised.
- R7: Only the low 20 bits of the selector word are matched against the supported indices. Upper bits do not affect the lookup.
- R8: A pulse on an event with no binding produces no strobe. It sets `unmapped_seen` one cycle later, and the flag then stays set until reset.
- R9: A write takes effect at the clock edge that samples it. A pulse in the same cycle as the write is routed by the previous bindings.
- R10: Pulses that arrive together are all routed. Two events bound to the same counter give one strobe on that counter.
- R11: `wr_err` is high for exactly the one cycle after a rejected write, and low after every accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Selector write strobe |
| wr_idx | input | CIDX_W (5) | Counter index being programmed |
| wr_sel | input | SEL_W (64) | Selector word; low 20 bits are the event index |
| evt_pulse | input | 5 | One bit per supported event |
| inc_strobe | output | MAX_CTRS (32) | Increment strobe per counter number |
| wr_err | output | 1 | Rejected-write pulse, one cycle after the write |
| unmapped_seen | output | 1 | Sticky: an unbound event has pulsed |

## Verification
Two cases are hard to reach from the ports. In the first, a pulse arrives in the same cycle as a write that would change its routing. In the second, several events share one counter and one of them is then released by a zero write. The stimulus first binds two events to one counter and a third event elsewhere, and fires all three together. It then zero-writes that counter while pulsing one of its events, so the strobe still appears once. The next pulse then shows the shared bindings gone and the unrelated one intact. Unbound pulses are held back until late in the sequence, so that the sticky flag is seen to stay low through all earlier activity.

// File: rtl/ert_pkg.sv
package ert_pkg;
    localparam int EVT_W   = 20;
    localparam int NUM_EVT = 5;

    typedef enum int {
        SLOT_CYCLES  = 0,
        SLOT_INSTR   = 1,
        SLOT_DTLB_RD = 2,
        SLOT_DTLB_WR = 3,
        SLOT_ITLB    = 4
    } evt_slot_e;

    // generic hardware event: type 0
    function automatic logic [EVT_W-1:0] mk_generic(input logic [15:0] code);
        return {4'h0, code};
    endfunction

    // cache event: type 1, code = {cache id, operation, result}
    function automatic logic [EVT_W-1:0] mk_cache(input logic [12:0] cache_id,
                                                  input logic [1:0]  op,
                                                  input logic        res);
        return {4'h1, cache_id, op, res};
    endfunction

    function automatic logic [EVT_W-1:0] slot_code(input int slot);
        case (slot)
            SLOT_CYCLES:  return mk_generic(16'h0001);
            SLOT_INSTR:   return mk_generic(16'h0002);
            SLOT_DTLB_RD: return mk_cache(13'd3, 2'd0, 1'b1);
            SLOT_DTLB_WR: return mk_cache(13'd3, 2'd1, 1'b1);
            SLOT_ITLB:    return mk_cache(13'd4, 2'd0, 1'b1);
            default:      return '0;
        endcase
    endfunction
endpackage

// File: rtl/ert_sel_decode.sv
module ert_sel_decode
    import ert_pkg::*;
#(
    parameter int SEL_W = 64
) (
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_EVT-1:0] hit,
    output logic               is_zero
);
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_match
        assign hit[e] = (sel[EVT_W-1:0] == slot_code(e));
    end

    assign is_zero = (sel == '0);

    // distinct codes can never match together (R3)
    always_comb begin
        p_onehot_hit_r3: assert ($onehot0(hit))
            else $error("selector matched more than one event slot");
    end
endmodule

// File: rtl/ert_ctr_check.sv
module ert_ctr_check #(
    parameter int MAX_CTRS  = 32,
    parameter int NUM_CTRS  = 8,
    parameter int FIRST_CTR = 3,
    localparam int CIDX_W   = $clog2(MAX_CTRS)
) (
    input  logic [CIDX_W-1:0]   idx,
    output logic                idx_ok,
    output logic [MAX_CTRS-1:0] avail_mask
);
    for (genvar c = 0; c < MAX_CTRS; c++) begin : g_avail
        if (c >= FIRST_CTR && c < FIRST_CTR + NUM_CTRS) begin : g_on
            assign avail_mask[c] = 1'b1;
        end else begin : g_off
            assign avail_mask[c] = 1'b0;
        end
    end

    assign idx_ok = avail_mask[idx];
endmodule

// File: rtl/ert_route.sv
module ert_route
    import ert_pkg::*;
#(
    parameter int MAX_CTRS = 32,
    localparam int CIDX_W  = $clog2(MAX_CTRS)
) (
    input  logic [NUM_EVT-1:0]             evt_pulse,
    input  logic [NUM_EVT-1:0]             bound,
    input  logic [NUM_EVT-1:0][CIDX_W-1:0] target,
    output logic [MAX_CTRS-1:0]            strobe,
    output logic                           miss
);
    for (genvar c = 0; c < MAX_CTRS; c++) begin : g_ctr
        logic [NUM_EVT-1:0] sel_here;
        for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
            assign sel_here[e] = evt_pulse[e] && bound[e] &&
                                 (target[e] == CIDX_W'(c));
        end
        assign strobe[c] = |sel_here;
    end

    assign miss = |(evt_pulse & ~bound);

    // an unbound pulse alone never strobes a counter (R8)
    always_comb begin
        p_quiet_when_unbound_r8: assert (!((evt_pulse & bound) == '0 && strobe != '0))
            else $error("strobe without a bound event");
    end
endmodule

// File: rtl/evt_ctr_router.sv
module evt_ctr_router
    import ert_pkg::*;
#(
    parameter int MAX_CTRS  = 32,
    parameter int NUM_CTRS  = 8,
    parameter int SEL_W     = 64,
    localparam int CIDX_W   = $clog2(MAX_CTRS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CIDX_W-1:0]   wr_idx,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [NUM_EVT-1:0]  evt_pulse,
    output logic [MAX_CTRS-1:0] inc_strobe,
    output logic                wr_err,
    output logic                unmapped_seen
);
    typedef struct packed {
        logic [NUM_EVT-1:0]             bound;
        logic [NUM_EVT-1:0][CIDX_W-1:0] target;
        logic                           err;
        logic                           sticky;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_EVT-1:0]  hit;
    logic                sel_zero;
    logic                idx_ok;
    logic [MAX_CTRS-1:0] avail_mask;
    logic                miss;

    ert_sel_decode #(.SEL_W(SEL_W)) u_dec (
        .sel     (wr_sel),
        .hit     (hit),
        .is_zero (sel_zero)
    );

    ert_ctr_check #(.MAX_CTRS(MAX_CTRS), .NUM_CTRS(NUM_CTRS), .FIRST_CTR(3)) u_chk (
        .idx        (wr_idx),
        .idx_ok     (idx_ok),
        .avail_mask (avail_mask)
    );

    ert_route #(.MAX_CTRS(MAX_CTRS)) u_route (
        .evt_pulse (evt_pulse),
        .bound     (st_q.bound),
        .target    (st_q.target),
        .strobe    (inc_strobe),
        .miss      (miss)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr_en) begin
            if (!idx_ok) begin
                st_d.err = 1'b1;
            end else if (sel_zero) begin
                for (int e = 0; e < NUM_EVT; e++) begin
                    if (st_q.bound[e] && st_q.target[e] == wr_idx) begin
                        st_d.bound[e] = 1'b0;
                    end
                end
            end else if (|hit) begin
                for (int e = 0; e < NUM_EVT; e++) begin
                    if (hit[e] && !st_q.bound[e]) begin
                        st_d.bound[e]  = 1'b1;
                        st_d.target[e] = wr_idx;
                    end
                end
            end else begin
                st_d.err = 1'b1;
            end
        end
        if (miss) begin
            st_d.sticky = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_err        = st_q.err;
    assign unmapped_seen = st_q.sticky;

    p_bad_index_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !idx_ok) |=> wr_err);

    p_unsupported_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_ok && !sel_zero && hit == '0) |=> (wr_err && $stable(st_q.bound)));

    p_first_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_ok && (hit & st_q.bound) != '0) |=> ($stable(st_q.target) && !wr_err));

    p_sticky_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_seen |=> unmapped_seen);

    p_strobe_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_strobe & ~avail_mask) == '0);

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_zero_chk
        p_zero_unbinds_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && idx_ok && sel_zero) |=>
                !(st_q.bound[e] && st_q.target[e] == $past(wr_idx)));
    end
endmodule

// File: tb/tb_evt_ctr_router.sv
module tb_evt_ctr_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_sel = '0;
    logic [4:0]  evt_pulse = '0;
    logic [31:0] inc_strobe;
    logic        wr_err;
    logic        unmapped_seen;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    evt_ctr_router dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_sel        (wr_sel),
        .evt_pulse     (evt_pulse),
        .inc_strobe    (inc_strobe),
        .wr_err        (wr_err),
        .unmapped_seen (unmapped_seen)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  idx;
        logic [63:0] sel;
        logic [4:0]  ev;
        logic [31:0] xstb;
        logic        xerr;
        logic        xstk;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd4,  64'h1,                  5'b00000, 32'h0,      1'b0, 1'b0, 4'd2},  // R2 bind cycles->4
        '{1'b0, 5'd0,  64'h0,                  5'b00001, 32'h10,     1'b0, 1'b0, 4'd2},  // R2 route
        '{1'b1, 5'd2,  64'h2,                  5'b00001, 32'h10,     1'b1, 1'b0, 4'd4},  // R4 low index
        '{1'b1, 5'd11, 64'h2,                  5'b00000, 32'h0,      1'b1, 1'b0, 4'd4},  // R4 high index
        '{1'b1, 5'd5,  64'h12345,              5'b00000, 32'h0,      1'b1, 1'b0, 4'd3},  // R3 unsupported
        '{1'b1, 5'd5,  64'hABCD_0000_0001_0019, 5'b00000, 32'h0,     1'b0, 1'b0, 4'd7},  // R7 upper bits, R11 err drops
        '{1'b0, 5'd0,  64'h0,                  5'b00100, 32'h20,     1'b0, 1'b0, 4'd7},  // R7 route dtlb rd->5
        '{1'b1, 5'd6,  64'h10019,              5'b00000, 32'h0,      1'b0, 1'b0, 4'd5},  // R5 rebind ignored
        '{1'b0, 5'd0,  64'h0,                  5'b00100, 32'h20,     1'b0, 1'b0, 4'd5},  // R5 still ->5
        '{1'b1, 5'd6,  64'h1001B,              5'b00000, 32'h0,      1'b0, 1'b0, 4'd2},  // R2 dtlb wr->6
        '{1'b1, 5'd4,  64'h2,                  5'b00000, 32'h0,      1'b0, 1'b0, 4'd2},  // R2 instr->4
        '{1'b0, 5'd0,  64'h0,                  5'b01011, 32'h50,     1'b0, 1'b0, 4'd10}, // R10 shared + separate
        '{1'b1, 5'd4,  64'h0,                  5'b00001, 32'h10,     1'b0, 1'b0, 4'd9},  // R9 old map, R6 clear 4
        '{1'b0, 5'd0,  64'h0,                  5'b00100, 32'h20,     1'b0, 1'b0, 4'd6},  // R6 others kept
        '{1'b1, 5'd10, 64'h10021,              5'b00000, 32'h0,      1'b0, 1'b0, 4'd4},  // R4 top index ok
        '{1'b0, 5'd0,  64'h0,                  5'b10000, 32'h400,    1'b0, 1'b0, 4'd2},  // R2 itlb->10
        '{1'b0, 5'd0,  64'h0,                  5'b00001, 32'h0,      1'b0, 1'b1, 4'd8},  // R8 unbound cycles
        '{1'b0, 5'd0,  64'h0,                  5'b00010, 32'h0,      1'b0, 1'b1, 4'd8},  // R8 unbound instr
        '{1'b1, 5'd3,  64'h1,                  5'b00001, 32'h0,      1'b0, 1'b1, 4'd9},  // R9 same-cycle uses old
        '{1'b0, 5'd0,  64'h0,                  5'b00001, 32'h8,      1'b0, 1'b1, 4'd4},  // R4 bottom index ok
        '{1'b1, 5'd7,  64'h0,                  5'b00000, 32'h0,      1'b0, 1'b1, 4'd6},  // R6 clear empty
        '{1'b1, 5'd3,  64'h1_0000_0000,        5'b00000, 32'h0,      1'b1, 1'b1, 4'd3},  // R3 nonzero, no code
        '{1'b0, 5'd0,  64'h0,                  5'b00001, 32'h8,      1'b0, 1'b1, 4'd11}  // R11 err one cycle
    };

    task automatic check(input string what, input int req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL R1 watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #2;
        check("reset strobe", 1, 64'(inc_strobe), 64'h0);
        check("reset err", 1, 64'(wr_err), 64'h0);
        check("reset sticky", 1, 64'(unmapped_seen), 64'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en     = VECS[i].we;
            wr_idx    = VECS[i].idx;
            wr_sel    = VECS[i].sel;
            evt_pulse = VECS[i].ev;
            #2;
            check($sformatf("vec %0d strobe", i), int'(VECS[i].req), 64'(inc_strobe), 64'(VECS[i].xstb));
            @(negedge clk);
            wr_en = 1'b0;
            evt_pulse = '0;
            check($sformatf("vec %0d err", i), int'(VECS[i].req), 64'(wr_err), 64'(VECS[i].xerr));
            check($sformatf("vec %0d sticky", i), int'(VECS[i].req), 64'(unmapped_seen), 64'(VECS[i].xstk));
        end

        // R1 reset clears bindings and sticky flag
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("reset clears sticky", 1, 64'(unmapped_seen), 64'h0);
        evt_pulse = 5'b11111;
        #2;
        check("no binding after reset", 1, 64'(inc_strobe), 64'h0);
        @(negedge clk);
        evt_pulse = '0;
        check("sticky after unbound burst", 8, 64'(unmapped_seen), 64'h1);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule